// File: doc/BRIEF.md
# Two-Register Peripheral with Switch Readback

This block is a small peripheral on an APB3 bus. It holds two 32-bit storage words that the bus master loads by writes, and it samples two single-bit switch inputs that the master sees by reads. Address decoding looks only at the low 8 bits of the bus address. Offset 0x00 selects the first word and the first switch. Offset 0x04 selects the second word and the second switch.

Writes store data. Reads return switch state and never the stored words. Bit 0 of the first word drives a lamp output, so software can turn an indicator on and off with one store. The block never inserts wait states and never reports an error. Decoding of the peripheral select from the full address space is done outside the block.

Top module: `apb_regsw`

## Requirements
- R1: While rst_n is low, both storage words are cleared to zero and lamp is 0.
- R2: On a rising clock edge with psel, penable and pwrite all high and paddr[7:0] equal to 0x00, word A takes the value of pwdata.
- R3: On a rising clock edge with psel, penable and pwrite all high and paddr[7:0] equal to 0x04, word B takes the value of pwdata.
- R4: A write to any other low-byte offset, a write with penable low (setup phase), or a write with psel low leaves both words unchanged. This is observed through lamp.
- R5: Bits 31:8 of paddr do not affect decoding. For example, 0x00001004 selects word B.
- R6: When pwrite is low, prdata is {31'b0, sw_a} at offset 0x00 and {31'b0, sw_b} at offset 0x04. It is zero at every other offset and whenever psel is low.
- R7: pready is always 1 and pslverr is always 0.
- R8: lamp equals bit 0 of word A. It changes on the clock edge that completes a write to offset 0x00 and on no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Bus address; only bits 7:0 are decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, always high |
| pslverr | output | 1 | Transfer error, always low |
| sw_a | input | 1 | Switch read at offset 0x00 |
| sw_b | input | 1 | Switch read at offset 0x04 |
| lamp | output | 1 | Follows bit 0 of word A |

## Verification
The stored words cannot be read back, so word A is visible at the ports only through lamp, and only through its bit 0. A wrong word A value, or a spurious load from a setup-phase, unselected or mis-addressed write, shows on lamp one cycle after the offending edge. It shows only if bit 0 differs from the correct value, so the stimulus alternates bit 0 between writes. Word B has no port-visible effect. The read path is combinational, so a decode fault shows on prdata in the same cycle as the access.

// File: rtl/apb_regsw.sv
module apb_regsw #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int DEC_W = 8,
  parameter logic [DEC_W-1:0] OFS_A = 8'h00,
  parameter logic [DEC_W-1:0] OFS_B = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          sw_a,
  input  logic          sw_b,
  output logic          lamp
);
  logic [DW-1:0] word_a, word_b;
  logic [DEC_W-1:0] ofs;
  logic hit_a, hit_b, wr_go;

  assign ofs   = paddr[DEC_W-1:0];
  assign hit_a = (ofs == OFS_A);
  assign hit_b = (ofs == OFS_B);
  assign wr_go = psel && penable && pwrite;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
    end else if (wr_go) begin
      if (hit_a) word_a <= pwdata;
      if (hit_b) word_b <= pwdata;
    end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_a) prdata[0] = sw_a;
      else if (hit_b) prdata[0] = sw_b;
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign lamp    = word_a[0];

  AST_LAMP_RESET: assert property (@(posedge clk) !rst_n |=> (lamp == 1'b0 || rst_n)); // R1
  AST_LAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && hit_a) |=> $stable(lamp)); // R8
  AST_LAMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && hit_a) |=> lamp == $past(pwdata[0])); // R2
  AST_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && hit_b) |=> word_b == $past(pwdata)); // R3
  AST_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    prdata[DW-1:1] == '0); // R6
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> prdata == '0); // R6
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R7
endmodule

// File: tb/apb_regsw_test.sv
module apb_regsw_test;
  localparam int CLK_PER = 10;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, sw_a = 0, sw_b = 0;
  logic [31:0] paddr = 0, pwdata = 0;
  logic [31:0] prdata;
  logic pready, pslverr, lamp;
  int checks = 0, errors = 0;
  bit model_lamp = 0;
  bit done = 0;

  apb_regsw uut (.clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
                 .prdata, .pready, .pslverr, .sw_a, .sw_b, .lamp);

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model: lamp updates only on a completed write to low byte 0x00
  always @(posedge clk)
    if (!rst_n) model_lamp <= 0;
    else if (psel && penable && pwrite && paddr[7:0] == 8'h00) model_lamp <= pwdata[0];

  // per-cycle comparison at the falling edge
  always @(negedge clk) if (rst_n) begin
    chk("R8", {31'b0, lamp}, {31'b0, model_lamp});
    chk("R7", {30'b0, pready, pslverr}, 32'h2);
    if (psel && !pwrite)
      chk("R6", prdata, paddr[7:0] == 8'h00 ? {31'b0, sw_a} :
                        paddr[7:0] == 8'h04 ? {31'b0, sw_b} : 32'h0);
    if (!psel) chk("R6", prdata, 32'h0);
  end

  task automatic xfer(bit wr, logic [31:0] a, logic [31:0] d, bit setup_only = 0);
    @(posedge clk); #1;
    psel = 1; pwrite = wr; paddr = a; pwdata = d; penable = 0;
    if (!setup_only) begin
      @(posedge clk); #1; penable = 1;
    end
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  initial begin
    #(CLK_PER*1000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PER*3 + 3);
    chk("R1", {31'b0, lamp}, 0);
    rst_n = 1;
    xfer(1, 32'h0000_1000, 32'hDEAD_BEE1); #2; chk("R2", {31'b0, lamp}, 1);
    xfer(1, 32'h0000_1004, 32'h0000_0000); #2; chk("R3", {31'b0, lamp}, 1);
    xfer(1, 32'h0000_0008, 32'h0); #2; chk("R4", {31'b0, lamp}, 1);
    xfer(1, 32'h0000_0000, 32'h0, 1); #2; chk("R4", {31'b0, lamp}, 1);
    @(posedge clk); #1; pwrite = 1; paddr = 0; pwdata = 0; penable = 1;
    @(posedge clk); #1; penable = 0; pwrite = 0; #1; chk("R4", {31'b0, lamp}, 1);
    xfer(1, 32'hFFFF_FF00, 32'h2); #2; chk("R5", {31'b0, lamp}, 0);
    xfer(1, 32'h1234_5600, 32'h3); #2; chk("R2", {31'b0, lamp}, 1);
    sw_a = 1; sw_b = 0;
    xfer(0, 32'h0000_1000, 0); xfer(0, 32'h0000_1004, 0);
    sw_a = 0; sw_b = 1;
    xfer(0, 32'hABCD_EF00, 0); xfer(0, 32'h0000_0004, 0); xfer(0, 32'h0000_0010, 0);
    @(posedge clk); #1; psel = 1; pwrite = 0; paddr = 32'h4; #1;
    chk("R6", prdata, 32'h1);
    paddr = 32'h0; #1; chk("R6", prdata, 32'h0);
    psel = 0; #1; chk("R6", prdata, 32'h0);
    rst_n = 0; #2; chk("R1", {31'b0, lamp}, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule